// File: doc/BRIEF.md
# Row-Hit-First DRAM Command Scheduler

This block sits in front of one DRAM channel and decides, every clock cycle, which single DRAM command goes out next. Requests are written into a small buffer. Each request carries a bank, a row, a column, a read/write flag and an arrival stamp. The scheduler keeps the open/closed state and the open row of every bank. From those it works out which requests can be served with a column command right away. It also works out which requests first need a row command: a precharge to close a conflicting row, or an activate to open their own row.

Column commands that hit an open row go ahead of row commands. Inside each of these two groups, the request with the oldest arrival stamp wins. Two legality gates apply:
- a per-bank down-counter spaces activates to the same bank;
- a channel-wide down-counter holds reads back after a write.

A configuration input selects the row-buffer policy. In the open policy, rows stay open until a conflicting request needs the bank. In the closed policy, an open bank is precharged as soon as no buffered request still targets its open row.

Top module: `dram_cmd_sched`

## Requirements
- R1: After reset no command is issued (`cmdValid` low), the buffer is empty (`reqReady` high) and every bank is closed.
- R2: At most one command issues per cycle. `cmdKind` encodes 0 = ACTIVATE, 1 = PRECHARGE, 2 = READ, 3 = WRITE. ACTIVATE carries the row and column 0. PRECHARGE carries row 0 and column 0. READ and WRITE carry the request's row and column.
- R3: A READ or WRITE whose request hits the open row of its bank, and is legal, is issued in preference to any ACTIVATE or PRECHARGE.
- R4: Among legal column commands, the request with the oldest arrival stamp is served first, whatever its buffer slot.
- R5: Among legal row commands, the one belonging to the oldest request is issued first.
- R6: A request to a closed bank gets an ACTIVATE and then its column command. A request to a bank open on another row gets PRECHARGE, ACTIVATE, then its column command.
- R7: With `closedMode` low, a row stays open after its accesses, and a later request to that row is served without a new ACTIVATE.
- R8: With `closedMode` high, a bank is precharged once no buffered request targets its open row. While one still does, the row is kept open.
- R9: Two ACTIVATEs to the same bank issue at least T_RC cycles apart.
- R10: A READ issues no earlier than T_WTR cycles after the most recent WRITE.
- R11: A request leaves the buffer when its column command issues. `reqReady` is low exactly while all buffer slots are occupied.
- R12: A PRECHARGE requested by a conflicting request is withheld while any buffered request still hits that bank's open row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| closedMode | input | 1 | 1 = closed-row policy, 0 = open-row policy |
| reqValid | input | 1 | New request present this cycle |
| reqBank | input | BANK_W | Request bank |
| reqRow | input | ROW_W | Request row |
| reqCol | input | COL_W | Request column |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqReady | output | 1 | A buffer slot is free; request accepted when reqValid is also high |
| cmdValid | output | 1 | A command issues at the coming clock edge |
| cmdKind | output | 2 | Command encoding (see R2) |
| cmdBank | output | BANK_W | Command bank |
| cmdRow | output | ROW_W | Command row field |
| cmdCol | output | COL_W | Command column field |

## Verification
The bench builds the scheduler with four buffer slots, four banks, T_RC = 5 and T_WTR = 4. With only four slots, a run of conflicting requests to one bank fills the buffer in a few cycles, so the `reqReady` drop and recovery can be observed. The short timing windows let a single scenario show:
- an activate held back by the same-bank spacing;
- several reads held back by a write, then released together, so the age ordering decides among them.

Exact issue gaps are measured against both windows.

// File: rtl/sched_pkg.sv
package sched_pkg;

  typedef enum logic [1:0] {
    CMD_ACT = 2'd0,
    CMD_PRE = 2'd1,
    CMD_RD  = 2'd2,
    CMD_WR  = 2'd3
  } cmd_kind_e;

  // Strobes from the control module to the datapath for the command issued
  // at the coming clock edge.
  typedef struct packed {
    logic doAct;
    logic doPre;
    logic doCol;
    logic doWrite;
  } sched_strobe_t;

endpackage

// File: rtl/sched_store.sv
module sched_store
  import sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 16,
  parameter int T_RC        = 6,
  parameter int T_WTR       = 3,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES),
  localparam int RC_W       = $clog2(T_RC + 1),
  localparam int WTR_W      = $clog2(T_WTR + 1)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               reqValid,
  input  logic [BANK_W-1:0]                  reqBank,
  input  logic [ROW_W-1:0]                   reqRow,
  input  logic [COL_W-1:0]                   reqCol,
  input  logic                               reqWrite,
  output logic                               reqReady,
  input  sched_strobe_t                      strobe,
  input  logic [IDX_W-1:0]                   selIdx,
  input  logic [BANK_W-1:0]                  selBank,
  output logic [NUM_ENTRIES-1:0]             entValid,
  output logic [NUM_ENTRIES-1:0][BANK_W-1:0] entBank,
  output logic [NUM_ENTRIES-1:0][ROW_W-1:0]  entRow,
  output logic [NUM_ENTRIES-1:0][COL_W-1:0]  entCol,
  output logic [NUM_ENTRIES-1:0]             entWrite,
  output logic [NUM_ENTRIES-1:0][AGE_W-1:0]  entAge,
  output logic [NUM_BANKS-1:0]               bankOpen,
  output logic [NUM_BANKS-1:0][ROW_W-1:0]    openRow,
  output logic [NUM_BANKS-1:0]               rcIdle,
  output logic                               wtrIdle
);

  logic [NUM_BANKS-1:0][RC_W-1:0] rcCnt;
  logic [WTR_W-1:0]               wtrCnt;
  logic [AGE_W-1:0]               ageCtr;
  logic [IDX_W-1:0]               freeIdx;
  logic                           anyFree;

  // Lowest free slot receives the next request.
  always_comb begin
    anyFree = 1'b0;
    freeIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) begin
        anyFree = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
  end

  assign reqReady = anyFree;

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++) rcIdle[b] = (rcCnt[b] == '0);
  end

  assign wtrIdle = (wtrCnt == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      entBank  <= '0;
      entRow   <= '0;
      entCol   <= '0;
      entWrite <= '0;
      entAge   <= '0;
      bankOpen <= '0;
      openRow  <= '0;
      rcCnt    <= '0;
      wtrCnt   <= '0;
      ageCtr   <= '0;
    end else begin
      if (strobe.doCol) entValid[selIdx] <= 1'b0;
      if (reqValid && anyFree) begin
        entValid[freeIdx] <= 1'b1;
        entBank[freeIdx]  <= reqBank;
        entRow[freeIdx]   <= reqRow;
        entCol[freeIdx]   <= reqCol;
        entWrite[freeIdx] <= reqWrite;
        entAge[freeIdx]   <= ageCtr;
        ageCtr            <= ageCtr + 1'b1;
      end
      if (strobe.doAct) begin
        bankOpen[selBank] <= 1'b1;
        openRow[selBank]  <= entRow[selIdx];
      end
      if (strobe.doPre) bankOpen[selBank] <= 1'b0;
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (strobe.doAct && selBank == BANK_W'(b)) rcCnt[b] <= RC_W'(T_RC - 1);
        else if (rcCnt[b] != '0)                    rcCnt[b] <= rcCnt[b] - 1'b1;
      end
      if (strobe.doCol && strobe.doWrite) wtrCnt <= WTR_W'(T_WTR - 1);
      else if (wtrCnt != '0)              wtrCnt <= wtrCnt - 1'b1;
    end
  end

  assert_act_spacing_R9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |-> rcCnt[selBank] == '0);

  assert_read_after_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.doCol && !strobe.doWrite) |-> wtrCnt == '0);

  assert_act_closed_bank_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doAct |-> !bankOpen[selBank]);

  assert_column_hits_open_row_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doCol |-> (entValid[selIdx] && bankOpen[selBank] &&
                      entBank[selIdx] == selBank && openRow[selBank] == entRow[selIdx]));

  assert_accept_fills_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> entValid != '0);

endmodule

// File: rtl/sched_ctrl.sv
module sched_ctrl
  import sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 16,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               closedMode,
  input  logic [NUM_ENTRIES-1:0]             entValid,
  input  logic [NUM_ENTRIES-1:0][BANK_W-1:0] entBank,
  input  logic [NUM_ENTRIES-1:0][ROW_W-1:0]  entRow,
  input  logic [NUM_ENTRIES-1:0][COL_W-1:0]  entCol,
  input  logic [NUM_ENTRIES-1:0]             entWrite,
  input  logic [NUM_ENTRIES-1:0][AGE_W-1:0]  entAge,
  input  logic [NUM_BANKS-1:0]               bankOpen,
  input  logic [NUM_BANKS-1:0][ROW_W-1:0]    openRow,
  input  logic [NUM_BANKS-1:0]               rcIdle,
  input  logic                               wtrIdle,
  output sched_strobe_t                      strobe,
  output logic [IDX_W-1:0]                   selIdx,
  output logic [BANK_W-1:0]                  selBank,
  output logic                               cmdValid,
  output cmd_kind_e                          cmdKind,
  output logic [ROW_W-1:0]                   cmdRow,
  output logic [COL_W-1:0]                   cmdCol
);

  logic [NUM_BANKS-1:0]   hitAny;
  logic [NUM_ENTRIES-1:0] hitE, colOk, actOk, preOk;
  logic                   colFound, rowFound, idleFound;
  logic [IDX_W-1:0]       colIdx, rowIdx;
  logic [AGE_W-1:0]       colAge, rowAge;
  logic [BANK_W-1:0]      idleBank;

  // Wrap-tolerant age compare: a is older than b.
  function automatic logic older(input logic [AGE_W-1:0] a, input logic [AGE_W-1:0] b);
    logic [AGE_W-1:0] d;
    d = a - b;
    return d[AGE_W-1];
  endfunction

  always_comb begin
    hitAny = '0;
    hitE   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      hitE[i] = entValid[i] && bankOpen[entBank[i]] && (openRow[entBank[i]] == entRow[i]);
      if (hitE[i]) hitAny[entBank[i]] = 1'b1;
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      colOk[i] = hitE[i] && (entWrite[i] || wtrIdle);
      actOk[i] = entValid[i] && !bankOpen[entBank[i]] && rcIdle[entBank[i]];
      preOk[i] = entValid[i] && bankOpen[entBank[i]] && !hitAny[entBank[i]];
    end
  end

  always_comb begin
    colFound = 1'b0;
    colIdx   = '0;
    colAge   = '0;
    rowFound = 1'b0;
    rowIdx   = '0;
    rowAge   = '0;
    for (int i = 0; i < NUM_ENTRIES; i++) begin
      if (colOk[i] && (!colFound || older(entAge[i], colAge))) begin
        colFound = 1'b1;
        colIdx   = IDX_W'(i);
        colAge   = entAge[i];
      end
      if ((actOk[i] || preOk[i]) && (!rowFound || older(entAge[i], rowAge))) begin
        rowFound = 1'b1;
        rowIdx   = IDX_W'(i);
        rowAge   = entAge[i];
      end
    end
    idleFound = 1'b0;
    idleBank  = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (closedMode && bankOpen[b] && !hitAny[b]) begin
        idleFound = 1'b1;
        idleBank  = BANK_W'(b);
      end
    end
  end

  always_comb begin
    strobe   = '0;
    selIdx   = '0;
    selBank  = '0;
    cmdValid = 1'b0;
    cmdKind  = CMD_ACT;
    cmdRow   = '0;
    cmdCol   = '0;
    if (colFound) begin
      selIdx         = colIdx;
      selBank        = entBank[colIdx];
      strobe.doCol   = 1'b1;
      strobe.doWrite = entWrite[colIdx];
      cmdValid       = 1'b1;
      cmdKind        = entWrite[colIdx] ? CMD_WR : CMD_RD;
      cmdRow         = entRow[colIdx];
      cmdCol         = entCol[colIdx];
    end else if (rowFound) begin
      selIdx   = rowIdx;
      selBank  = entBank[rowIdx];
      cmdValid = 1'b1;
      if (actOk[rowIdx]) begin
        strobe.doAct = 1'b1;
        cmdKind      = CMD_ACT;
        cmdRow       = entRow[rowIdx];
      end else begin
        strobe.doPre = 1'b1;
        cmdKind      = CMD_PRE;
      end
    end else if (idleFound) begin
      selBank      = idleBank;
      strobe.doPre = 1'b1;
      cmdValid     = 1'b1;
      cmdKind      = CMD_PRE;
    end
  end

  assert_single_command_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.doAct, strobe.doPre, strobe.doCol}));

endmodule

// File: rtl/dram_cmd_sched.sv
module dram_cmd_sched
  import sched_pkg::*;
#(
  parameter int NUM_ENTRIES = 4,
  parameter int NUM_BANKS   = 4,
  parameter int ROW_W       = 8,
  parameter int COL_W       = 6,
  parameter int AGE_W       = 16,
  parameter int T_RC        = 6,
  parameter int T_WTR       = 3,
  localparam int BANK_W     = $clog2(NUM_BANKS),
  localparam int IDX_W      = $clog2(NUM_ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              closedMode,
  input  logic              reqValid,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [ROW_W-1:0]  reqRow,
  input  logic [COL_W-1:0]  reqCol,
  input  logic              reqWrite,
  output logic              reqReady,
  output logic              cmdValid,
  output logic [1:0]        cmdKind,
  output logic [BANK_W-1:0] cmdBank,
  output logic [ROW_W-1:0]  cmdRow,
  output logic [COL_W-1:0]  cmdCol
);

  sched_strobe_t                      strobe;
  logic [IDX_W-1:0]                   selIdx;
  logic [BANK_W-1:0]                  selBank;
  logic [NUM_ENTRIES-1:0]             entValid;
  logic [NUM_ENTRIES-1:0][BANK_W-1:0] entBank;
  logic [NUM_ENTRIES-1:0][ROW_W-1:0]  entRow;
  logic [NUM_ENTRIES-1:0][COL_W-1:0]  entCol;
  logic [NUM_ENTRIES-1:0]             entWrite;
  logic [NUM_ENTRIES-1:0][AGE_W-1:0]  entAge;
  logic [NUM_BANKS-1:0]               bankOpen;
  logic [NUM_BANKS-1:0][ROW_W-1:0]    openRow;
  logic [NUM_BANKS-1:0]               rcIdle;
  logic                               wtrIdle;
  cmd_kind_e                          kind;

  sched_store #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .AGE_W(AGE_W), .T_RC(T_RC), .T_WTR(T_WTR)
  ) u_store (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWrite(reqWrite), .reqReady(reqReady),
    .strobe(strobe), .selIdx(selIdx), .selBank(selBank),
    .entValid(entValid), .entBank(entBank), .entRow(entRow), .entCol(entCol),
    .entWrite(entWrite), .entAge(entAge),
    .bankOpen(bankOpen), .openRow(openRow), .rcIdle(rcIdle), .wtrIdle(wtrIdle)
  );

  sched_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W), .COL_W(COL_W),
    .AGE_W(AGE_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .closedMode(closedMode),
    .entValid(entValid), .entBank(entBank), .entRow(entRow), .entCol(entCol),
    .entWrite(entWrite), .entAge(entAge),
    .bankOpen(bankOpen), .openRow(openRow), .rcIdle(rcIdle), .wtrIdle(wtrIdle),
    .strobe(strobe), .selIdx(selIdx), .selBank(selBank),
    .cmdValid(cmdValid), .cmdKind(kind), .cmdRow(cmdRow), .cmdCol(cmdCol)
  );

  assign cmdKind = kind;
  assign cmdBank = selBank;

endmodule

// File: tb/dram_cmd_sched_bench.sv
`timescale 1ns/1ps
module dram_cmd_sched_bench;

  localparam int NE = 4, NB = 4, RW = 8, CW = 6, TRC = 5, TWTR = 4;
  localparam int K_ACT = 0, K_PRE = 1, K_RD = 2, K_WR = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          closedMode = 1'b0;
  logic          reqValid = 1'b0;
  logic [1:0]    reqBank = '0;
  logic [RW-1:0] reqRow = '0;
  logic [CW-1:0] reqCol = '0;
  logic          reqWrite = 1'b0;
  logic          reqReady, cmdValid;
  logic [1:0]    cmdKind, cmdBank;
  logic [RW-1:0] cmdRow;
  logic [CW-1:0] cmdCol;

  dram_cmd_sched #(.NUM_ENTRIES(NE), .NUM_BANKS(NB), .ROW_W(RW), .COL_W(CW),
                   .AGE_W(16), .T_RC(TRC), .T_WTR(TWTR)) u_dram_cmd_sched (
    .clk(clk), .rstN(rstN), .closedMode(closedMode),
    .reqValid(reqValid), .reqBank(reqBank), .reqRow(reqRow), .reqCol(reqCol),
    .reqWrite(reqWrite), .reqReady(reqReady),
    .cmdValid(cmdValid), .cmdKind(cmdKind), .cmdBank(cmdBank),
    .cmdRow(cmdRow), .cmdCol(cmdCol)
  );

  always #10 clk = ~clk;

  typedef struct {
    int    kind;
    int    bank;
    int    row;
    int    col;
    string tag;
  } exp_t;

  exp_t expQ[$];
  exp_t cur;
  int   nCheck = 0;
  int   nFail = 0;
  int   cyc = 0;
  int   lastAct[NB];
  int   lastWr = -1;
  bit   finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nCheck++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_cmd(input int kind, input int bank, input int row, input int col,
                            input string tag);
    exp_t e;
    e.kind = kind; e.bank = bank; e.row = row; e.col = col; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic push(input int bank, input int row, input int col, input bit wr);
    @(negedge clk);
    reqValid = 1'b1;
    reqBank  = 2'(bank);
    reqRow   = RW'(row);
    reqCol   = CW'(col);
    reqWrite = wr;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  task automatic do_reset(input bit mode);
    @(negedge clk);
    rstN = 1'b0;
    closedMode = mode;
    reqValid = 1'b0;
    repeat (3) @(negedge clk);
    for (int b = 0; b < NB; b++) lastAct[b] = -1;
    lastWr = -1;
    rstN = 1'b1;
  endtask

  task automatic drain(input string tag);
    repeat (30) @(negedge clk);
    chk(expQ.size() == 0, tag, expQ.size(), 0);
    expQ.delete();
  endtask

  // Monitor: compares every issued command with the scoreboard and measures gaps.
  always @(negedge clk) begin
    cyc++;
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        chk(1'b0, "R2 unexpected command kind", int'(cmdKind), -1);
      end else begin
        cur = expQ.pop_front();
        chk(int'(cmdKind) == cur.kind, {cur.tag, " kind"}, int'(cmdKind), cur.kind);
        chk(int'(cmdBank) == cur.bank, {cur.tag, " bank"}, int'(cmdBank), cur.bank);
        chk(int'(cmdRow) == cur.row, {cur.tag, " row"}, int'(cmdRow), cur.row);
        chk(int'(cmdCol) == cur.col, {cur.tag, " col"}, int'(cmdCol), cur.col);
      end
      if (int'(cmdKind) == K_ACT) begin
        if (lastAct[cmdBank] >= 0)
          chk(cyc - lastAct[cmdBank] >= TRC, "R9 activate gap", cyc - lastAct[cmdBank], TRC);
        lastAct[cmdBank] = cyc;
      end
      if (int'(cmdKind) == K_RD && lastWr >= 0)
        chk(cyc - lastWr >= TWTR, "R10 write-to-read gap", cyc - lastWr, TWTR);
      if (int'(cmdKind) == K_WR) lastWr = cyc;
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      chk(1'b0, "watchdog expired", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < NB; b++) lastAct[b] = -1;

    // R1: reset state
    do_reset(1'b0);
    @(negedge clk);
    chk(reqReady == 1'b1, "R1 reqReady after reset", int'(reqReady), 1);
    chk(cmdValid == 1'b0, "R1 cmdValid after reset", int'(cmdValid), 0);

    // Scenario A (open policy): R3, R6, R7, R9
    expect_cmd(K_ACT, 1, 10, 0, "R6 act closed bank");
    expect_cmd(K_RD,  1, 10, 3, "R4 oldest hit");
    expect_cmd(K_RD,  1, 10, 7, "R3 hit before conflict");
    expect_cmd(K_PRE, 1, 0,  0, "R6 pre conflict");
    expect_cmd(K_ACT, 1, 20, 0, "R9 act after rc");
    expect_cmd(K_RD,  1, 20, 1, "R6 column after act");
    push(1, 10, 3, 1'b0);
    push(1, 10, 7, 1'b0);
    push(1, 20, 1, 1'b0);
    repeat (15) @(negedge clk);
    chk(expQ.size() == 0, "R7 no precharge in open mode", expQ.size(), 0);
    expect_cmd(K_WR, 1, 20, 2, "R7 row still open");
    push(1, 20, 2, 1'b1);
    drain("R7 drain");

    // Scenario B (closed policy): R8
    do_reset(1'b1);
    expect_cmd(K_ACT, 2, 5, 0, "R8 act");
    expect_cmd(K_RD,  2, 5, 1, "R8 first read");
    expect_cmd(K_RD,  2, 5, 2, "R8 row kept for pending hit");
    expect_cmd(K_PRE, 2, 0, 0, "R8 auto precharge");
    push(2, 5, 1, 1'b0);
    push(2, 5, 2, 1'b0);
    drain("R8 drain");

    // Scenario C (open policy): R4, R10
    do_reset(1'b0);
    expect_cmd(K_ACT, 0, 1, 0, "R6 act bank0");
    expect_cmd(K_WR,  0, 1, 0, "R3 write hit");
    expect_cmd(K_ACT, 3, 2, 0, "R10 act while read blocked");
    expect_cmd(K_ACT, 2, 7, 0, "R10 act while read blocked");
    expect_cmd(K_RD,  3, 2, 4, "R4 oldest read first");
    expect_cmd(K_RD,  0, 1, 9, "R4 second oldest");
    expect_cmd(K_RD,  2, 7, 1, "R4 youngest in low slot");
    push(0, 1, 0, 1'b1);
    push(3, 2, 4, 1'b0);
    push(0, 1, 9, 1'b0);
    push(2, 7, 1, 1'b0);
    drain("R4 drain");

    // Scenario D (open policy): R5, R9
    do_reset(1'b0);
    expect_cmd(K_ACT, 1, 3, 0, "R6 act");
    expect_cmd(K_RD,  1, 3, 1, "R3 read");
    expect_cmd(K_PRE, 1, 0, 0, "R5 older row command first");
    expect_cmd(K_ACT, 2, 6, 0, "R5 younger act next");
    expect_cmd(K_RD,  2, 6, 3, "R3 read bank2");
    expect_cmd(K_ACT, 1, 8, 0, "R9 delayed act");
    expect_cmd(K_RD,  1, 8, 2, "R6 read after reopen");
    push(1, 3, 1, 1'b0);
    push(1, 8, 2, 1'b0);
    push(2, 6, 3, 1'b0);
    drain("R5 drain");

    // Scenario E (open policy): R12, R10
    do_reset(1'b0);
    expect_cmd(K_ACT, 0, 1, 0, "R6 act");
    expect_cmd(K_WR,  0, 1, 0, "R3 write");
    expect_cmd(K_RD,  0, 1, 5, "R12 pending hit served before precharge");
    expect_cmd(K_PRE, 0, 0, 0, "R12 precharge after hit");
    expect_cmd(K_ACT, 0, 2, 0, "R6 reopen");
    expect_cmd(K_RD,  0, 2, 1, "R6 conflict read");
    push(0, 1, 0, 1'b1);
    push(0, 2, 1, 1'b0);
    push(0, 1, 5, 1'b0);
    drain("R12 drain");

    // Scenario F (open policy): R11 buffer full, R5 ordering of conflicts
    do_reset(1'b0);
    for (int r = 1; r <= 5; r++) begin
      if (r > 1) expect_cmd(K_PRE, 0, 0, 0, "R5 precharge for oldest conflict");
      expect_cmd(K_ACT, 0, r, 0, "R6 act row");
      expect_cmd(K_RD,  0, r, r, "R11 read then removal");
    end
    for (int r = 1; r <= 5; r++) push(0, r, r, 1'b0);
    @(negedge clk);
    chk(reqReady == 1'b0, "R11 full buffer drops reqReady", int'(reqReady), 0);
    drain("R11 drain");
    chk(reqReady == 1'b1, "R11 reqReady after drain", int'(reqReady), 1);
    chk(cmdValid == 1'b0, "R2 idle after drain", int'(cmdValid), 0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCheck, nFail);
    $finish;
  end

endmodule